// File: doc/BRIEF.md
# Posted Write Buffer with Busy Flag

This block sits between a CPU request port and a slow external serial bus. When the CPU issues a single-word write, the block latches the address and data and acknowledges the CPU on the next cycle. The CPU is then free to continue. The block carries out the external write in the background and holds a busy status output high until the external side reports completion.

While the buffer is busy, any further write is acknowledged and then discarded. It is neither queued nor forwarded. A read that arrives while a write is in progress, whatever its address, is held without acknowledge. The read is issued on the external bus only after the pending write has finished, and the external read data is then returned to the CPU. The block does not decode addresses, so writes aimed at read-only regions are forwarded like any other write. The access-size input is ignored: every transfer is one aligned word.

The CPU holds its request until it sees the one-cycle acknowledge. The external side uses a request/done handshake.

Top module: `posted_wr_buf`

## Requirements
- R1: After reset, busy, cpuAck and extReq are all 0.
- R2: A write accepted while not busy is acknowledged (cpuAck=1) for exactly one cycle, in the cycle after the clock edge that latches it, without waiting for extDone.
- R3: busy is 1 from the cycle after a write is latched up to and including the cycle in which extDone is 1, and 0 in the cycle after that.
- R4: While extReq is 1 and extDone is 0, extReq stays 1 in the next cycle and extAddr, extWdata and extWe keep their values. For a buffered write, extWe=1 and extAddr/extWdata carry the latched address and data.
- R5: A write that arrives while busy is acknowledged in the next cycle and never reaches the external bus. Only the first write's address and data are transferred.
- R6: A read that arrives while busy gets no acknowledge and starts no external read (extWe stays 1) until the pending write's extDone. Only then is it issued with extWe=0.
- R7: A read completes with cpuAck=1 in the cycle after extDone, and cpuRdata equals the extRdata value present with extDone.
- R8: Writes are forwarded regardless of address value. This includes the top of the address space.
- R9: cpuSize has no effect. extAddr always has its two low bits at 0 (word-aligned, 32-bit data), and extWdata carries the full 32-bit cpuWdata.
- R10: A read that arrives while not busy is issued on the external bus (extReq=1, extWe=0) in the cycle after it is seen, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU request, held until cpuAck |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuSize | input | 2 | Access size, ignored |
| cpuAddr | input | AW | CPU byte address |
| cpuWdata | input | DW | CPU write data |
| cpuAck | output | 1 | One-cycle acknowledge to the CPU |
| cpuRdata | output | DW | Read data, valid with cpuAck on reads |
| busy | output | 1 | Posted write in progress |
| extReq | output | 1 | External bus request |
| extWe | output | 1 | External direction, 1 = write |
| extAddr | output | AW | Word-aligned external address |
| extWdata | output | DW | External write data |
| extDone | input | 1 | External transfer complete |
| extRdata | input | DW | External read data, valid with extDone |

## Verification
A controller stuck in the write state keeps busy and extWe high after extDone. This is visible in the very next cycle. A controller that skips the stall issues the read with extWe=0 while busy is still 1, which is seen at the ports within one cycle of the read request. A wrongly captured or cleared buffer register shows up as a changed extAddr or extWdata during an open request. It also shows up as a second write reaching the external side, detectable once that transfer is recorded. An acknowledge that arrives late or is lost stalls the CPU handshake, and the bench catches this with a bounded wait.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    IDLE          = 2'd0,
    WRITE_PENDING = 2'd1,
    READ_PENDING  = 2'd2,
    READ_RETURN   = 2'd3
  } pwbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchWr;
    logic latchRd;
    logic capRd;
    logic setAck;
    logic clrBusy;
    logic selWr;
  } pwbStrb_t;

endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      cpuWe,
  input  logic      ackQ,
  input  logic      extDone,
  output pwbStrb_t  strb,
  output logic      extReq
);

  pwbState_t state, stateNext;
  logic      newReq;

  assign newReq = cpuReq && !ackQ;

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    strb.selWr = (state == WRITE_PENDING);
    unique case (state)
      IDLE: begin
        if (newReq) begin
          if (cpuWe) begin
            strb.latchWr = 1'b1;
            strb.setAck  = 1'b1;
            stateNext    = WRITE_PENDING;
          end else begin
            strb.latchRd = 1'b1;
            stateNext    = READ_PENDING;
          end
        end
      end
      WRITE_PENDING: begin
        // a write arriving now is acknowledged and discarded
        if (newReq && cpuWe) strb.setAck = 1'b1;
        if (extDone) begin
          strb.clrBusy = 1'b1;
          if (newReq && !cpuWe) begin
            strb.latchRd = 1'b1;
            stateNext    = READ_PENDING;
          end else begin
            stateNext    = IDLE;
          end
        end
      end
      READ_PENDING: begin
        if (extDone) begin
          strb.capRd  = 1'b1;
          strb.setAck = 1'b1;
          stateNext   = READ_RETURN;
        end
      end
      READ_RETURN: begin
        stateNext = IDLE;
      end
      default: stateNext = IDLE;
    endcase
  end

  assign extReq = (state == WRITE_PENDING) || (state == READ_PENDING);

endmodule

// File: rtl/pwb_dpath.sv
module pwb_dpath
  import pwb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  pwbStrb_t      strb,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  input  logic [DW-1:0] extRdata,
  output logic          ackQ,
  output logic          busyQ,
  output logic          extWe,
  output logic [AW-1:0] extAddr,
  output logic [DW-1:0] extWdata,
  output logic [DW-1:0] cpuRdata
);

  localparam int ALIGN_BITS = $clog2(DW / 8);

  logic [AW-1:0] wrAddr, rdAddr, addrSel;
  logic [DW-1:0] wrData, rdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr <= '0;
      wrData <= '0;
      rdAddr <= '0;
      rdData <= '0;
      ackQ   <= 1'b0;
      busyQ  <= 1'b0;
    end else begin
      ackQ <= strb.setAck;
      if (strb.latchWr) begin
        wrAddr <= cpuAddr;
        wrData <= cpuWdata;
      end
      if (strb.latchRd) rdAddr <= cpuAddr;
      if (strb.capRd)   rdData <= extRdata;
      if (strb.latchWr)      busyQ <= 1'b1;
      else if (strb.clrBusy) busyQ <= 1'b0;
    end
  end

  assign addrSel  = strb.selWr ? wrAddr : rdAddr;
  assign extAddr  = {addrSel[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign extWdata = wrData;
  assign extWe    = strb.selWr;
  assign cpuRdata = rdData;

endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf
  import pwb_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [SIZE_W-1:0] cpuSize,
  input  logic [AW-1:0]     cpuAddr,
  input  logic [DW-1:0]     cpuWdata,
  output logic              cpuAck,
  output logic [DW-1:0]     cpuRdata,
  output logic              busy,
  output logic              extReq,
  output logic              extWe,
  output logic [AW-1:0]     extAddr,
  output logic [DW-1:0]     extWdata,
  input  logic              extDone,
  input  logic [DW-1:0]     extRdata
);

  pwbStrb_t strb;
  logic     ackQ;
  logic     unusedSize;

  // every transfer is one full word; the size field carries no meaning here
  assign unusedSize = ^cpuSize;

  pwb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuReq  (cpuReq),
    .cpuWe   (cpuWe),
    .ackQ    (ackQ),
    .extDone (extDone),
    .strb    (strb),
    .extReq  (extReq)
  );

  pwb_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .extRdata (extRdata),
    .ackQ     (ackQ),
    .busyQ    (busy),
    .extWe    (extWe),
    .extAddr  (extAddr),
    .extWdata (extWdata),
    .cpuRdata (cpuRdata)
  );

  assign cpuAck = ackQ;

endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuReq,
  input logic          cpuWe,
  input logic          cpuAck,
  input logic          busy,
  input logic          extReq,
  input logic          extWe,
  input logic [AW-1:0] extAddr,
  input logic [DW-1:0] extWdata,
  input logic          extDone
);

  a_r2_write_acked: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWe && !cpuAck && !extReq) |=> (cpuAck && busy));

  a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |=> !cpuAck);

  a_r3_busy_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busy && extDone) |=> !busy);

  a_r4_req_stable: assert property (@(posedge clk) disable iff (!rstN)
    (extReq && !extDone) |=> (extReq && $stable(extAddr) && $stable(extWdata) && $stable(extWe)));

  a_r5_drop_acked: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cpuReq && cpuWe && !cpuAck) |=> cpuAck);

  a_r6_busy_is_write: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (extReq && extWe));

  a_r9_aligned: assert property (@(posedge clk) disable iff (!rstN)
    extReq |-> (extAddr[1:0] == 2'b00));

endmodule

bind posted_wr_buf pwb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuWe    (cpuWe),
  .cpuAck   (cpuAck),
  .busy     (busy),
  .extReq   (extReq),
  .extWe    (extWe),
  .extAddr  (extAddr),
  .extWdata (extWdata),
  .extDone  (extDone)
);

// File: tb/sim_posted_wr_buf.sv
`timescale 1ns/1ps
module sim_posted_wr_buf;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [1:0]  cpuSize = 2'b10;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic        cpuAck;
  logic [31:0] cpuRdata;
  logic        busy, extReq, extWe;
  logic [31:0] extAddr, extWdata;
  logic        extDone = 1'b0;
  logic [31:0] extRdata = '0;

  int nChecks = 0;
  int nFail = 0;
  int extLat = 4;
  int wrCount = 0, rdCount = 0, seqNo = 0, lastWrSeq = 0, lastRdSeq = 0;
  logic [31:0] lastWrAddr, lastWrData, lastRdAddr;

  always #10 clk = ~clk;

  posted_wr_buf u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuSize(cpuSize),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuAck(cpuAck), .cpuRdata(cpuRdata),
    .busy(busy), .extReq(extReq), .extWe(extWe), .extAddr(extAddr),
    .extWdata(extWdata), .extDone(extDone), .extRdata(extRdata)
  );

  function automatic logic [31:0] rdPattern(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  // external bus model: records each transfer, answers after extLat cycles
  initial begin
    forever begin
      @(negedge clk);
      if (extDone) extDone = 1'b0;
      else if (extReq && rstN) begin
        seqNo++;
        if (extWe) begin
          wrCount++; lastWrAddr = extAddr; lastWrData = extWdata; lastWrSeq = seqNo;
        end else begin
          rdCount++; lastRdAddr = extAddr; lastRdSeq = seqNo;
          extRdata = rdPattern(extAddr);
        end
        repeat (extLat) @(negedge clk);
        extDone = 1'b1;
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 100 && (busy || extReq); i++) step();
    step();
  endtask

  task automatic waitAck(output bit got);
    got = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (cpuAck) begin got = 1'b1; break; end
      step();
    end
  endtask

  task automatic t_reset();
    chk(!busy && !cpuAck && !extReq, "R1 reset state", {busy, cpuAck, extReq}, 0);
  endtask

  task automatic t_write_basic(input logic [31:0] a, input logic [31:0] d, input string req);
    int cnt;
    int w0;
    w0 = wrCount;
    cpuReq = 1; cpuWe = 1; cpuAddr = a; cpuWdata = d;
    step();
    chk(cpuAck && !extDone, "R2 ack before ext done", cpuAck, 1);
    chk(busy, "R3 busy set", busy, 1);
    chk(extReq && extWe && extAddr == a && extWdata == d, {req, " R4 ext write"}, extAddr, a);
    cpuReq = 0;
    cnt = 1;
    step();
    chk(!cpuAck, "R2 ack single cycle", cpuAck, 0);
    if (busy) cnt++;
    for (int i = 0; i < 60 && busy; i++) begin
      chk(extAddr == a && extWdata == d, "R4 stable during request", extWdata, d);
      step();
      if (busy) cnt++;
    end
    chk(cnt == extLat + 1, "R3 busy duration", cnt, extLat + 1);
    chk(wrCount == w0 + 1 && lastWrAddr == a && lastWrData == d, {req, " write forwarded"}, lastWrAddr, a);
    waitIdle();
  endtask

  task automatic t_drop();
    int w0;
    w0 = wrCount;
    cpuReq = 1; cpuWe = 1; cpuAddr = 32'h0000_1000; cpuWdata = 32'h1111_2222;
    step(); cpuReq = 0; step();
    cpuReq = 1; cpuWe = 1; cpuAddr = 32'h0000_2000; cpuWdata = 32'h3333_4444; cpuSize = 2'b00;
    step();
    chk(cpuAck, "R5 dropped write acked", cpuAck, 1);
    chk(busy && extAddr == 32'h0000_1000, "R5 buffer unchanged", extAddr, 32'h0000_1000);
    cpuReq = 0;
    waitIdle(); waitIdle();
    chk(wrCount == w0 + 1, "R5 only one write on bus", wrCount, w0 + 1);
    chk(lastWrData == 32'h1111_2222, "R5 first data kept", lastWrData, 32'h1111_2222);
  endtask

  task automatic t_stall();
    int r0;
    bit got;
    r0 = rdCount;
    cpuReq = 1; cpuWe = 1; cpuAddr = 32'h0000_0400; cpuWdata = 32'hCAFE_0001;
    step(); cpuReq = 0; step();
    cpuReq = 1; cpuWe = 0; cpuAddr = 32'h0000_3ABC;
    for (int i = 0; i < 2; i++) begin
      step();
      chk(!cpuAck && busy && extWe && rdCount == r0, "R6 read held while busy", rdCount, r0);
    end
    waitAck(got);
    chk(got, "R6 stalled read completes", got, 1);
    chk(rdCount == r0 + 1 && lastRdSeq > lastWrSeq, "R6 read after write", lastRdSeq, lastWrSeq + 1);
    chk(lastRdAddr == 32'h0000_3ABC, "R6 read address", lastRdAddr, 32'h0000_3ABC);
    chk(cpuRdata == rdPattern(32'h0000_3ABC), "R7 read data", cpuRdata, rdPattern(32'h0000_3ABC));
    cpuReq = 0;
    waitIdle();
  endtask

  task automatic t_read_idle(input logic [31:0] a);
    bit got;
    int cyc;
    cpuReq = 1; cpuWe = 0; cpuAddr = a;
    step();
    chk(extReq && !extWe && !busy, "R10 read issued at once", {extReq, extWe, busy}, 3'b100);
    cyc = 0;
    for (int i = 0; i < 60 && !extDone; i++) begin step(); cyc++; end
    step();
    chk(cpuAck, "R7 ack cycle after done", cpuAck, 1);
    chk(cpuRdata == rdPattern({a[31:2], 2'b00}), "R7 read data", cpuRdata, rdPattern({a[31:2], 2'b00}));
    cpuReq = 0;
    waitAck(got);
    waitIdle();
  endtask

  task automatic t_size();
    cpuReq = 1; cpuWe = 1; cpuSize = 2'b00; cpuAddr = 32'h0000_0017; cpuWdata = 32'hDEAD_BEEF;
    step();
    chk(extAddr == 32'h0000_0014, "R9 aligned address", extAddr, 32'h0000_0014);
    chk(extWdata == 32'hDEAD_BEEF, "R9 full word data", extWdata, 32'hDEAD_BEEF);
    cpuReq = 0;
    waitIdle();
    cpuSize = 2'b10;
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rstN = 1;
    step();
    t_reset();
    t_write_basic(32'h0000_0100, 32'hA5A5_5A5A, "R2");
    extLat = 7;
    t_write_basic(32'hFFFF_FFFC, 32'h0123_4567, "R8");
    t_write_basic(32'h1FC0_0000, 32'h89AB_CDEF, "R8");
    extLat = 3;
    t_drop();
    t_stall();
    t_read_idle(32'h0000_5552);
    extLat = 1;
    t_read_idle(32'h0000_0010);
    t_size();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule